// File: doc/BRIEF.md
# UART Receive Queue with Line Status

This block sits behind the receive deserializer of a 16550-style serial channel. Each time the deserializer finishes a character, it offers the byte along with three flags: parity error, framing error and break. The block stores each accepted character, together with its own flags, in a first-in first-out queue of 128 entries. It presents the oldest character on a read-data port and assembles an 8-bit line status word for the CPU.

The error flags travel through the queue with their characters. Because of this, the head-of-queue status bits always describe the character the CPU is about to read. A counter of tagged entries drives a summary bit that stays set while any flagged character is still waiting. A long break on the line enters the queue once, not once per frame. When a character arrives and the queue is full, that character is discarded so the stored data stays intact, and a sticky overrun bit records the loss. The block also takes the transmit-side occupancy signals so it can report the two transmit-empty bits in the same status word.

Top module: `uart_rxq_lsr`

## Requirements
- R1: Accepted characters are returned on `rd_byte` in arrival order. `rd_byte` shows the oldest stored entry, and up to 128 entries are held.
- R2: Status bit 0 is 1 exactly when the queue holds at least one entry.
- R3: Status bit 7 is 1 while at least one stored entry carries a parity, framing or break tag. It returns to 0 once the last such entry has been read out.
- R4: Status bit 2 (parity) and bit 3 (framing) show the tags of the head entry only. They are 0 when the queue is empty.
- R5: A break character is stored as data 0x00 with its break tag and its framing tag set, and status bit 4 shows the head entry's break tag. Further break characters that follow a break with no ordinary character in between are not stored.
- R6: A character that arrives while the queue is full, with no read in the same cycle, is discarded. The stored entries are left unchanged, and status bit 1 (overrun) is set.
- R7: A status read (`lsr_rd`) clears bit 1 in the following cycle. If a new overrun happens in the same cycle as the status read, bit 1 stays set.
- R8: If a character arrives and a data read happens in the same cycle while the queue is full, the character is accepted and no overrun is flagged.
- R9: Status bit 5 is 1 when `tx_fifo_empty` is 1 and `tx_wr` is 0. It drops in the same cycle that `tx_wr` is asserted.
- R10: Status bit 6 is 1 only when bit 5 is 1 and `tx_shift_empty` is 1.
- R11: Reset empties the queue and clears the overrun and break state. With the transmit side idle, the status word then reads 0x60.
- R12: A data read while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: the deserializer has completed a character |
| rx_byte | input | 8 | Received data byte |
| rx_perr | input | 1 | Parity error flag for this character |
| rx_ferr | input | 1 | Framing error flag for this character |
| rx_brk | input | 1 | The character is a break frame |
| rd_pop | input | 1 | CPU data read; removes the head entry |
| lsr_rd | input | 1 | CPU status read; clears overrun |
| tx_fifo_empty | input | 1 | Transmit queue holds no data |
| tx_shift_empty | input | 1 | Transmit shift register holds no data |
| tx_wr | input | 1 | A byte is being written into the transmit queue this cycle |
| rd_byte | output | 8 | Data byte of the head entry |
| lsr | output | 8 | Line status word |

## Verification
The bench pushes a run of repeated break frames. A design that did not collapse them would show extra 0x00 entries, and the summary bit would stay set too long. It fills the queue to 128 entries and then offers a flagged character. A design that stored it or counted its tag would corrupt the order or raise bit 7. It then times a status read in the same cycle as a new overrun, where a design that let the clear win would lose the event. It also does a simultaneous push and pop on a full queue, where a wrong design would flag an overrun or drop the byte. Finally, it checks that bit 5 drops in the same cycle as a transmit write, which catches a design that registers it a cycle late.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [BYTE_W-1:0] data;
  } rxq_entry_t;

  function automatic logic entry_tagged(input rxq_entry_t e);
    return e.brk | e.ferr | e.perr;
  endfunction
endpackage

// File: rtl/rxq_break_filter.sv
module rxq_break_filter
  import uart_rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_perr,
  input  logic              in_ferr,
  input  logic              in_brk,
  output logic              out_valid,
  output rxq_entry_t        out_entry
);
  logic brk_run_q, brk_run_d;

  always_comb begin
    brk_run_d = brk_run_q;
    if (in_valid) brk_run_d = in_brk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_run_q <= 1'b0;
    else if (in_valid) brk_run_q <= brk_run_d;
  end

  always_comb begin
    out_valid = in_valid & ~(in_brk & brk_run_q);
    if (in_brk) begin
      out_entry.data = '0;
      out_entry.brk  = 1'b1;
      out_entry.ferr = 1'b1;
      out_entry.perr = 1'b0;
    end else begin
      out_entry.data = in_byte;
      out_entry.brk  = 1'b0;
      out_entry.ferr = in_ferr;
      out_entry.perr = in_perr;
    end
  end

  // R5: a break that continues the current break run is never forwarded
  a_r5_break_once: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_brk && brk_run_q) |-> !out_valid);
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import uart_rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  rxq_entry_t push_entry,
  input  logic       pop,
  output rxq_entry_t head,
  output logic       not_empty,
  output logic       any_tagged,
  output logic       overflow
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  rxq_entry_t   mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d, tag_q, tag_d;
  logic full, empty, push_ok, pop_ok;

  assign full      = (cnt_q == FULL_CNT);
  assign empty     = (cnt_q == '0);
  assign pop_ok    = pop & ~empty;
  assign push_ok   = push & (~full | pop_ok);
  assign overflow  = push & full & ~pop_ok;
  assign head      = mem[rd_ptr_q];
  assign not_empty = ~empty;
  assign any_tagged = (tag_q != '0);

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    tag_d    = tag_q;
    if (push_ok) wr_ptr_d = (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
    if (pop_ok)  rd_ptr_d = (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    case ({push_ok & entry_tagged(push_entry), pop_ok & entry_tagged(head)})
      2'b10:   tag_d = tag_q + 1'b1;
      2'b01:   tag_d = tag_q - 1'b1;
      default: tag_d = tag_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      tag_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      tag_q    <= tag_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= push_entry;
  end

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  a_r3_tags_within_count: assert property (@(posedge clk) disable iff (!rst_n)
    tag_q <= cnt_q);
  a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt_q == FULL_CNT));
  a_r12_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (cnt_q == '0));
  a_r8_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && full) |=> (cnt_q == FULL_CNT));
endmodule

// File: rtl/rxq_ovr_flag.sv
module rxq_ovr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_d;

  always_comb begin
    flag_d = flag;
    if (clr) flag_d = 1'b0;
    if (set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end

  a_r6_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);
endmodule

// File: rtl/uart_rxq_lsr.sv
module uart_rxq_lsr
  import uart_rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       rx_perr,
  input  logic       rx_ferr,
  input  logic       rx_brk,
  input  logic       rd_pop,
  input  logic       lsr_rd,
  input  logic       tx_fifo_empty,
  input  logic       tx_shift_empty,
  input  logic       tx_wr,
  output logic [7:0] rd_byte,
  output logic [7:0] lsr
);
  logic [1:0] rst_sync_q;
  logic       rst_i;
  logic       f_valid;
  rxq_entry_t f_entry, head;
  logic       not_empty, any_tagged, overflow, ovr_flag;
  logic       thr_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  rxq_break_filter u_brk (
    .clk(clk), .rst_n(rst_i),
    .in_valid(rx_valid), .in_byte(rx_byte),
    .in_perr(rx_perr), .in_ferr(rx_ferr), .in_brk(rx_brk),
    .out_valid(f_valid), .out_entry(f_entry)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_i),
    .push(f_valid), .push_entry(f_entry), .pop(rd_pop),
    .head(head), .not_empty(not_empty),
    .any_tagged(any_tagged), .overflow(overflow)
  );

  rxq_ovr_flag u_ovr (
    .clk(clk), .rst_n(rst_i),
    .set(overflow), .clr(lsr_rd), .flag(ovr_flag)
  );

  assign thr_empty = tx_fifo_empty & ~tx_wr;
  assign rd_byte   = head.data;

  always_comb begin
    lsr[0] = not_empty;
    lsr[1] = ovr_flag;
    lsr[2] = not_empty & head.perr;
    lsr[3] = not_empty & head.ferr;
    lsr[4] = not_empty & head.brk;
    lsr[5] = thr_empty;
    lsr[6] = thr_empty & tx_shift_empty;
    lsr[7] = any_tagged;
  end

  a_r10_temt_implies_thre: assert property (@(posedge clk) disable iff (!rst_i)
    lsr[6] |-> lsr[5]);
  a_r3_summary_needs_data: assert property (@(posedge clk) disable iff (!rst_i)
    lsr[7] |-> lsr[0]);
  a_r4_head_tags_need_data: assert property (@(posedge clk) disable iff (!rst_i)
    (lsr[2] || lsr[3] || lsr[4]) |-> lsr[0]);
endmodule

// File: tb/sim_uart_rxq_lsr.sv
module sim_uart_rxq_lsr;
  logic clk = 1'b0;
  logic rst_n;
  logic rx_valid, rx_perr, rx_ferr, rx_brk, rd_pop, lsr_rd;
  logic tx_fifo_empty, tx_shift_empty, tx_wr;
  logic [7:0] rx_byte, rd_byte, lsr;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_rxq_lsr u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rd_pop(rd_pop),
    .lsr_rd(lsr_rd), .tx_fifo_empty(tx_fifo_empty), .tx_shift_empty(tx_shift_empty),
    .tx_wr(tx_wr), .rd_byte(rd_byte), .lsr(lsr)
  );

  // vector: valid, byte, perr, ferr, brk, pop, lsr_rd, exp_lsr, exp_rbr
  localparam int NV = 14;
  localparam logic [29:0] VEC [NV] = '{
    {1'b1, 8'h41, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h61, 8'h41}, // R1 R2
    {1'b1, 8'h42, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hE1, 8'h41}, // R3
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hE5, 8'h42}, // R4 parity head
    {1'b1, 8'h55, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hE5, 8'h42}, // R5 break in
    {1'b1, 8'h55, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hE5, 8'h42}, // R5 dropped
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hF9, 8'h00}, // R5 head break
    {1'b1, 8'h33, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hF9, 8'h00},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h61, 8'h33}, // R5 single entry, R3 clears
    {1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hE1, 8'h33}, // R5 new break run
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hF9, 8'h00},
    {1'b1, 8'h7E, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hF9, 8'h00},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hE9, 8'h7E}, // R4 framing head
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h60, 8'h00}, // R2 empty
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h60, 8'h00}  // R12 pop on empty
  };

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    rx_valid = 1'b0; rx_byte = 8'h00; rx_perr = 1'b0; rx_ferr = 1'b0;
    rx_brk = 1'b0; rd_pop = 1'b0; lsr_rd = 1'b0;
  endtask

  task automatic step(input logic v, input logic [7:0] d, input logic p, input logic f,
                      input logic b, input logic rd, input logic rl);
    @(negedge clk);
    rx_valid = v; rx_byte = d; rx_perr = p; rx_ferr = f; rx_brk = b;
    rd_pop = rd; lsr_rd = rl;
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(lsr == 8'h60, "R11 reset", lsr, 8'h60);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [29:0] v;
    bit order_ok;
    rst_n = 1'b0;
    idle_inputs();
    tx_fifo_empty = 1'b1; tx_shift_empty = 1'b1; tx_wr = 1'b0;
    repeat (2) @(negedge clk);
    do_reset();

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      step(v[29], v[28:21], v[20], v[19], v[18], v[17], v[16]);
      check(lsr == v[15:8], "R2/R3/R4/R5 table lsr", lsr, v[15:8]);
      if (v[8]) check(rd_byte == v[7:0], "R1 table head byte", rd_byte, v[7:0]);
    end

    // R6: fill to 128, then a flagged byte with a same-cycle status read (R7 set wins)
    for (int i = 0; i < 128; i++) step(1'b1, 8'(i), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check(lsr == 8'h61, "R1 full clean", lsr, 8'h61);
    step(1'b1, 8'hEE, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    check(lsr == 8'h63, "R6 overrun set, R7 set wins", lsr, 8'h63);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    check(lsr == 8'h61, "R7 lsr read clears overrun", lsr, 8'h61);
    // R8: push and pop on full
    step(1'b1, 8'hAA, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    check(lsr == 8'hE1, "R8 full swap no overrun", lsr, 8'hE1);
    order_ok = 1'b1;
    for (int i = 1; i < 128; i++) begin
      if (rd_byte != 8'(i)) begin
        order_ok = 1'b0;
        $display("FAIL R1 drain order: actual %02h expected %02h", rd_byte, 8'(i));
      end
      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    end
    check(order_ok, "R6 stored entries intact", 8'h00, 8'h00);
    check(rd_byte == 8'hAA, "R8 swapped byte kept", rd_byte, 8'hAA);
    check(lsr == 8'hE9, "R4 framing head after drain", lsr, 8'hE9);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check(lsr == 8'h60, "R2 empty after drain", lsr, 8'h60);

    // R9 / R10: transmit side
    @(negedge clk);
    tx_wr = 1'b1;
    #1;
    check(lsr[6:5] == 2'b00, "R9 same-cycle tx write", {6'd0, lsr[6:5]}, 8'h00);
    tx_wr = 1'b0;
    tx_shift_empty = 1'b0;
    #1;
    check(lsr[6:5] == 2'b01, "R10 shift busy", {6'd0, lsr[6:5]}, 8'h01);
    tx_fifo_empty = 1'b0;
    #1;
    check(lsr[6:5] == 2'b00, "R9 tx fifo busy", {6'd0, lsr[6:5]}, 8'h00);
    tx_fifo_empty = 1'b1; tx_shift_empty = 1'b1;
    #1;
    check(lsr[6:5] == 2'b11, "R10 both empty", {6'd0, lsr[6:5]}, 8'h03);

    // R11: reset mid-stream
    step(1'b1, 8'h10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 8'h11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check(lsr == 8'hE5, "R4 parity head before reset", lsr, 8'hE5);
    do_reset();
    check(lsr == 8'h60, "R11 after release", lsr, 8'h60);
    // break state cleared by reset: a break is stored again
    step(1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check(lsr == 8'hF9, "R5 R11 break after reset", lsr, 8'hF9);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule